// File: doc/BRIEF.md
# Register-Programmed Pad Routing Crossbar

This block sits between a bank of routable pads and the core-side signals of a chip. Every routable pad owns a byte-wide configuration register. That register chooses which internal source drives the pad, carries a software data bit, and gates the pad's output driver. A second group of registers lets each core-side receive input pick which pad or signal feeds it. Software reaches all of these through a simple synchronous byte port that has an address, write data, a write strobe and registered read data.

The source space uses 6-bit codes. Code 0 keeps the pad's built-in route. Codes 1 to 30 select entries of the source vector. These entries include UART transmit, RTS and transmit-enable lines and four clocks. Code 31 hands the pad to its software data bit. Codes starting at 32 select the sampled inputs of the pads themselves, so one pad can mirror another, and any number of pads may select the same source at once. A control register gates the SPI clock and MOSI lines and requests a hardware reboot, either from software or from a pushbutton. A read-only status register returns the first six pad inputs and two extra DIO inputs.

Top module: `pinxbar_top`

## Requirements
- R1: Pad k has a register at address k, with the select code in bits 7:2, the data bit in bit 1 and the output enable in bit 0. All registers reset to 0 and read back what was written.
- R2: Select code 0 routes pad k from its default code PAD_DEF_BASE+k. With the default parameters, pad k follows srcIn[k].
- R3: A select code c in 1..30 drives the pad from srcIn[c-1].
- R4: Select code 31 drives the pad from its own data bit (bit 1).
- R5: A select code 32+m, with m below NUM_PADS, drives the pad from padIn[m]. Several pads may select the same code, and each of them follows it.
- R6: Any select code above 31+NUM_PADS drives the pad low. With the default parameters, this covers codes 45 to 63.
- R7: padOe[k] equals bit 0 of pad k's register. When that bit is 0, the pad's input is still visible in the status register.
- R8: Core input j has a register at address NUM_PADS+j with its select in bits 7:2. Bits 1:0 read 0. coreOut[j] follows the selected source as in R3, R5 and R6, and code 31 gives 0. Code 0 routes it from padIn[CORE_DEF_BASE+j].
- R9: The status register at address NUM_PADS+NUM_CORE+1 reads {dioIn[1:0], padIn[5:0]}. Writes to it have no effect.
- R10: The control register sits at address NUM_PADS+NUM_CORE. When its bit 0 is 1, spiClkOut and spiMosiOut always follow their inputs. When bit 0 is 0, they follow their inputs only while spiCsN is 0, and are otherwise 0.
- R11: Writing the control register with bit 2 set raises rebootReq for exactly the following cycle. Bit 2 reads back 0.
- R12: While control bit 1 is set, a rising edge of pushBtn raises rebootReq for one cycle. When a software request and a button edge coincide, they give a single one-cycle pulse.
- R13: rdData shows the addressed register one cycle after the address is presented. Reserved control bits 7:2 read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 6 | Register address for read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| srcIn | input | 30 | Internal sources for codes 1..30 |
| padIn | input | NUM_PADS | Sampled pad inputs |
| dioIn | input | 2 | Extra DIO inputs for the status register |
| padOut | output | NUM_PADS | Pad output values |
| padOe | output | NUM_PADS | Pad output enables |
| coreOut | output | NUM_CORE | Routed core-side inputs |
| spiCsN | input | 1 | SPI chip select, active low |
| spiClkIn | input | 1 | SPI clock from the core |
| spiMosiIn | input | 1 | SPI data from the core |
| spiClkOut | output | 1 | Gated SPI clock |
| spiMosiOut | output | 1 | Gated SPI data |
| pushBtn | input | 1 | Pushbutton level, already synchronized |
| rebootReq | output | 1 | One-cycle reboot request |

## Verification
A software reboot write and a pushbutton rising edge can both arrive in the same clock cycle. The bench provokes this by raising pushBtn at the same falling edge at which it presents the control write, with both bit 2 and the button-enable bit set. It then expects rebootReq high on the next sample and low on the one after, which is a single pulse rather than two. A press made while the enable is still clear must produce no pulse. Apart from this case, the bench judges every routing change at the pad ports one cycle after the write, and it checks every read through a scoreboard queue.

// File: rtl/pinxbar_pkg.sv
package pinxbar_pkg;
  localparam int ADDR_W    = 6;
  localparam int SEL_W     = 6;
  localparam int NUM_SRC   = 30;
  localparam int CODE_GPIO = 31;
  localparam int CODE_PAD0 = 32;
  localparam int CODE_SPAN = 64;

  // write strobes from the control path into the datapath
  typedef struct packed {
    logic              padWr;
    logic              coreWr;
    logic              ctrlWr;
    logic [ADDR_W-1:0] idx;
    logic [7:0]        data;
  } xbarStrobe_t;
endpackage

// File: rtl/pinxbar_ctrl.sv
module pinxbar_ctrl
  import pinxbar_pkg::*;
#(
  parameter int NUM_PADS = 13,
  parameter int NUM_CORE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              pbEn,
  input  logic              pushBtn,
  output xbarStrobe_t       strobe,
  output logic              rebootReq
);
  localparam logic [ADDR_W-1:0] A_CORE0 = ADDR_W'(NUM_PADS);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(NUM_PADS + NUM_CORE);

  logic isPad, isCore, isCtrl, swReboot, pbPrev, pbEdge;

  assign isPad  = addr < A_CORE0;
  assign isCore = (addr >= A_CORE0) && (addr < A_CTRL);
  assign isCtrl = addr == A_CTRL;

  always_comb begin
    strobe        = '0;
    strobe.padWr  = wrEn && isPad;
    strobe.coreWr = wrEn && isCore;
    strobe.ctrlWr = wrEn && isCtrl;
    strobe.idx    = isCore ? (addr - A_CORE0) : addr;
    strobe.data   = wrData;
  end

  assign swReboot = wrEn && isCtrl && wrData[2];
  assign pbEdge   = pushBtn && !pbPrev && pbEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      pbPrev    <= 1'b0;
      rebootReq <= 1'b0;
    end else begin
      pbPrev    <= pushBtn;
      rebootReq <= swReboot || pbEdge;
    end
  end
endmodule

// File: rtl/pinxbar_dp.sv
module pinxbar_dp
  import pinxbar_pkg::*;
#(
  parameter int NUM_PADS      = 13,
  parameter int NUM_CORE      = 4,
  parameter int PAD_DEF_BASE  = 1,
  parameter int CORE_DEF_BASE = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  xbarStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [7:0]          rdData,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic [1:0]          dioIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_CORE-1:0] coreOut,
  input  logic                spiCsN,
  input  logic                spiClkIn,
  input  logic                spiMosiIn,
  output logic                spiClkOut,
  output logic                spiMosiOut,
  output logic                pbEn
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_PADS + NUM_CORE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_PADS + NUM_CORE + 1);

  logic [7:0]       padReg  [NUM_PADS];
  logic [SEL_W-1:0] coreSel [NUM_CORE];
  logic [1:0]       ctrlReg;
  logic [CODE_SPAN-1:0] srcAll;
  logic [7:0]       rdMux;

  // register bank
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_PADS; k++) padReg[k] <= '0;
      for (int j = 0; j < NUM_CORE; j++) coreSel[j] <= '0;
      ctrlReg <= '0;
    end else begin
      for (int k = 0; k < NUM_PADS; k++)
        if (strobe.padWr && strobe.idx == ADDR_W'(k)) padReg[k] <= strobe.data;
      for (int j = 0; j < NUM_CORE; j++)
        if (strobe.coreWr && strobe.idx == ADDR_W'(j)) coreSel[j] <= strobe.data[7:2];
      if (strobe.ctrlWr) ctrlReg <= strobe.data[1:0];
    end
  end

  // flat source space indexed by select code
  always_comb begin
    srcAll = '0;
    srcAll[NUM_SRC:1] = srcIn;
    srcAll[CODE_PAD0 +: NUM_PADS] = padIn;
  end

  for (genvar gk = 0; gk < NUM_PADS; gk++) begin : g_pad
    logic [SEL_W-1:0] sel, eff;
    assign sel        = padReg[gk][7:2];
    assign eff        = (sel == '0) ? SEL_W'(PAD_DEF_BASE + gk) : sel;
    assign padOut[gk] = (eff == SEL_W'(CODE_GPIO)) ? padReg[gk][1] : srcAll[eff];
    assign padOe[gk]  = padReg[gk][0];
  end

  for (genvar gj = 0; gj < NUM_CORE; gj++) begin : g_core
    logic [SEL_W-1:0] eff;
    assign eff         = (coreSel[gj] == '0) ? SEL_W'(CODE_PAD0 + CORE_DEF_BASE + gj)
                                             : coreSel[gj];
    assign coreOut[gj] = srcAll[eff];
  end

  // SPI gating
  logic spiPass;
  assign spiPass    = ctrlReg[0] || !spiCsN;
  assign spiClkOut  = spiPass && spiClkIn;
  assign spiMosiOut = spiPass && spiMosiIn;
  assign pbEn       = ctrlReg[1];

  // read path
  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NUM_PADS; k++)
      if (rdAddr == ADDR_W'(k)) rdMux = padReg[k];
    for (int j = 0; j < NUM_CORE; j++)
      if (rdAddr == ADDR_W'(NUM_PADS + j)) rdMux = {coreSel[j], 2'b00};
    if (rdAddr == A_CTRL) rdMux = {6'b0, ctrlReg};
    if (rdAddr == A_STAT) rdMux = {dioIn, padIn[5:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else     rdData <= rdMux;
  end
endmodule

// File: rtl/pinxbar_top.sv
module pinxbar_top
  import pinxbar_pkg::*;
#(
  parameter int NUM_PADS      = 13,
  parameter int NUM_CORE      = 4,
  parameter int PAD_DEF_BASE  = 1,
  parameter int CORE_DEF_BASE = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [5:0]          addr,
  input  logic                wrEn,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  input  logic [29:0]         srcIn,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic [1:0]          dioIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [NUM_PADS-1:0] padOe,
  output logic [NUM_CORE-1:0] coreOut,
  input  logic                spiCsN,
  input  logic                spiClkIn,
  input  logic                spiMosiIn,
  output logic                spiClkOut,
  output logic                spiMosiOut,
  input  logic                pushBtn,
  output logic                rebootReq
);
  xbarStrobe_t strobe;
  logic        pbEn;

  pinxbar_ctrl #(.NUM_PADS(NUM_PADS), .NUM_CORE(NUM_CORE)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .pbEn(pbEn), .pushBtn(pushBtn), .strobe(strobe), .rebootReq(rebootReq)
  );

  pinxbar_dp #(.NUM_PADS(NUM_PADS), .NUM_CORE(NUM_CORE),
               .PAD_DEF_BASE(PAD_DEF_BASE), .CORE_DEF_BASE(CORE_DEF_BASE)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdAddr(addr), .rdData(rdData),
    .srcIn(srcIn), .padIn(padIn), .dioIn(dioIn), .padOut(padOut), .padOe(padOe),
    .coreOut(coreOut), .spiCsN(spiCsN), .spiClkIn(spiClkIn), .spiMosiIn(spiMosiIn),
    .spiClkOut(spiClkOut), .spiMosiOut(spiMosiOut), .pbEn(pbEn)
  );
endmodule

// File: rtl/pinxbar_chk.sv
module pinxbar_chk #(
  parameter int NUM_PADS = 13,
  parameter int NUM_CORE = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [5:0]          addr,
  input logic                wrEn,
  input logic [7:0]          wrData,
  input logic [7:0]          rdData,
  input logic [NUM_PADS-1:0] padIn,
  input logic [1:0]          dioIn,
  input logic [NUM_PADS-1:0] padOut,
  input logic [NUM_PADS-1:0] padOe,
  input logic                spiCsN,
  input logic                spiClkIn,
  input logic                spiClkOut,
  input logic                pushBtn,
  input logic                rebootReq
);
  localparam logic [5:0] A_CTRL   = 6'(NUM_PADS + NUM_CORE);
  localparam logic [5:0] A_STAT   = 6'(NUM_PADS + NUM_CORE + 1);
  localparam logic [5:0] MAX_CODE = 6'(31 + NUM_PADS);

  assert_oe_follows_R7: assert property (@(posedge clk) disable iff (rst)
    $past(wrEn && addr == 6'd0) |-> padOe[0] == $past(wrData[0]));

  assert_gpio_data_R4: assert property (@(posedge clk) disable iff (rst)
    $past(wrEn && addr == 6'd0 && wrData[7:2] == 6'd31) |-> padOut[0] == $past(wrData[1]));

  assert_unassigned_low_R6: assert property (@(posedge clk) disable iff (rst)
    $past(wrEn && addr == 6'd0 && wrData[7:2] > MAX_CODE) |-> !padOut[0]);

  assert_spi_cs_pass_R10: assert property (@(posedge clk) disable iff (rst)
    !spiCsN |-> spiClkOut == spiClkIn);

  assert_status_read_R9: assert property (@(posedge clk) disable iff (rst)
    $past(addr == A_STAT) |-> rdData == $past({dioIn, padIn[5:0]}));

  assert_reboot_cause_R11: assert property (@(posedge clk) disable iff (rst)
    rebootReq |-> $past(wrEn && addr == A_CTRL && wrData[2]) || $past(pushBtn));
endmodule

bind pinxbar_top pinxbar_chk #(.NUM_PADS(NUM_PADS), .NUM_CORE(NUM_CORE)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .padIn(padIn), .dioIn(dioIn), .padOut(padOut), .padOe(padOe), .spiCsN(spiCsN),
  .spiClkIn(spiClkIn), .spiClkOut(spiClkOut), .pushBtn(pushBtn), .rebootReq(rebootReq)
);

// File: tb/pinxbar_top_tb.sv
`timescale 1ns/1ps
module pinxbar_top_tb;
  localparam int NP = 13;
  localparam int NC = 4;
  localparam logic [5:0] A_CTRL = 6'(NP + NC);
  localparam logic [5:0] A_STAT = 6'(NP + NC + 1);

  logic clk = 0, rst = 1, wrEn = 0, spiCsN = 1, spiClkIn = 0, spiMosiIn = 0, pushBtn = 0;
  logic [5:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [29:0] srcIn = 30'h15555555;
  logic [NP-1:0] padIn = 13'h0A5B;
  logic [1:0] dioIn = 2'b10;
  logic [NP-1:0] padOut, padOe;
  logic [NC-1:0] coreOut;
  logic spiClkOut, spiMosiOut, rebootReq;

  int total = 0, bad = 0;
  logic rdIssue = 0, rdLat = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  pinxbar_top u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .srcIn(srcIn), .padIn(padIn), .dioIn(dioIn), .padOut(padOut), .padOe(padOe),
    .coreOut(coreOut), .spiCsN(spiCsN), .spiClkIn(spiClkIn), .spiMosiIn(spiMosiIn),
    .spiClkOut(spiClkOut), .spiMosiOut(spiMosiOut), .pushBtn(pushBtn), .rebootReq(rebootReq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rdIssue = 1; expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); rdIssue = 0;
  endtask

  always @(posedge clk) rdLat <= rdIssue;

  always @(negedge clk) begin
    if (rdLat) begin
      if (expQ.size() == 0) chk(8'hEE, 8'h00, "R13 unexpected read");
      else chk(rdData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 / R2: reset state
    chk(8'(padOe), 8'h00, "R1 padOe low after reset");
    for (int k = 0; k < NP; k++) chk(8'(padOut[k]), 8'(srcIn[k]), "R2 default route");
    rd(6'd0, 8'h00, "R1 pad reg reset");
    rd(A_STAT, {2'b10, 6'h1B}, "R9 status read");
    rd(6'd40, 8'h00, "R13 unmapped read");

    // R3 / R7: functional source with OE
    wr(6'd2, 8'h15);
    chk(8'(padOe[2]), 8'h01, "R7 OE set");
    chk(8'(padOut[2]), 8'(srcIn[4]), "R3 code5 route");
    @(negedge clk); srcIn[4] = ~srcIn[4]; #1;
    chk(8'(padOut[2]), 8'(srcIn[4]), "R3 code5 toggle");
    rd(6'd2, 8'h15, "R1 readback");

    // R4: GPIO
    wr(6'd2, 8'h7F); chk(8'(padOut[2]), 8'h01, "R4 gpio one");
    wr(6'd2, 8'h7D); chk(8'(padOut[2]), 8'h00, "R4 gpio zero");
    wr(6'd2, 8'h01); chk(8'(padOut[2]), 8'(srcIn[2]), "R2 back to default");

    // R5: fan-out and mirror
    wr(6'd3, 8'h1D); wr(6'd4, 8'h1D);
    @(negedge clk); srcIn[6] = 1; #1;
    chk(8'(padOut[4:3]), 8'h03, "R5 fanout high");
    @(negedge clk); srcIn[6] = 0; #1;
    chk(8'(padOut[4:3]), 8'h00, "R5 fanout low");
    chk(8'(padOut[5]), 8'(srcIn[5]), "R2 untouched pad default");
    wr(6'd6, 8'h85);
    @(negedge clk); padIn[1] = 1; #1; chk(8'(padOut[6]), 8'h01, "R5 mirror high");
    @(negedge clk); padIn[1] = 0; #1; chk(8'(padOut[6]), 8'h00, "R5 mirror low");

    // R6: unassigned codes
    @(negedge clk); srcIn = '1; padIn = '1;
    wr(6'd7, 8'hB5); chk(8'(padOut[7]), 8'h00, "R6 code45 low");
    wr(6'd7, 8'hFF); chk(8'(padOut[7]), 8'h00, "R6 code63 low");

    // R7: OE off, input still visible
    wr(6'd6, 8'h84);
    chk(8'(padOe[6]), 8'h00, "R7 OE cleared");
    @(negedge clk); padIn[5:0] = 6'h2C;
    rd(A_STAT, {2'b10, 6'h2C}, "R7 input visible via status");

    // R8: core inputs
    @(negedge clk); padIn[0] = 0; #1; chk(8'(coreOut[0]), 8'h00, "R8 core default low");
    @(negedge clk); padIn[0] = 1; #1; chk(8'(coreOut[0]), 8'h01, "R8 core default high");
    wr(6'd14, 8'h93);
    @(negedge clk); padIn[4] = 0; #1; chk(8'(coreOut[1]), 8'h00, "R8 core pad select");
    rd(6'd14, 8'h90, "R8 reserved bits zero");
    wr(6'd15, 8'h7C); chk(8'(coreOut[2]), 8'h00, "R8 core gpio code zero");

    // R9: status writes ignored
    wr(A_STAT, 8'hFF);
    rd(A_STAT, {2'b10, 6'h2D}, "R9 status unchanged");
    rd(6'd0, 8'h00, "R9 write did not reach pad0");

    // R13: control reserved bits
    wr(A_CTRL, 8'hFB);
    rd(A_CTRL, 8'h03, "R13 ctrl reserved");

    // R10: SPI gating
    @(negedge clk); spiCsN = 1; spiClkIn = 1; spiMosiIn = 1; #1;
    chk({6'b0, spiClkOut, spiMosiOut}, 8'h03, "R10 always pass");
    wr(A_CTRL, 8'h00);
    chk({6'b0, spiClkOut, spiMosiOut}, 8'h00, "R10 blocked cs high");
    @(negedge clk); spiCsN = 0; #1;
    chk({6'b0, spiClkOut, spiMosiOut}, 8'h03, "R10 pass cs low");
    @(negedge clk); spiCsN = 1;

    // R11: software reboot
    wr(A_CTRL, 8'h04);
    chk(8'(rebootReq), 8'h01, "R11 reboot pulse");
    @(negedge clk); chk(8'(rebootReq), 8'h00, "R11 pulse one cycle");
    rd(A_CTRL, 8'h00, "R11 bit reads zero");

    // R12: pushbutton
    @(negedge clk); pushBtn = 1;
    @(negedge clk); chk(8'(rebootReq), 8'h00, "R12 button disabled");
    pushBtn = 0;
    wr(A_CTRL, 8'h02);
    @(negedge clk); pushBtn = 1;
    @(negedge clk); chk(8'(rebootReq), 8'h01, "R12 button pulse");
    @(negedge clk); chk(8'(rebootReq), 8'h00, "R12 held button single");
    pushBtn = 0;
    @(negedge clk);
    // both sources in the same cycle
    addr = A_CTRL; wrData = 8'h06; wrEn = 1; pushBtn = 1;
    @(negedge clk); wrEn = 0;
    chk(8'(rebootReq), 8'h01, "R12 coincident pulse");
    @(negedge clk); chk(8'(rebootReq), 8'h00, "R12 coincident single");
    pushBtn = 0;

    repeat (3) @(negedge clk);
    chk(8'(expQ.size()), 8'h00, "R13 reads drained");
    finishRun();
  end
endmodule